// File: doc/BRIEF.md
# Sampling Converter Serial Output Engine

This block is the digital serial side of a 12-bit sampling converter. A host drives an active-low chip select and a serial clock. The block samples both with a faster system clock, finds their edges, and shifts out a 16-bit frame: four zeros, then the 12-bit sample, most significant bit first. The analog front end is not modelled. The sample value comes in on a parallel port, and the block latches it when chip select falls.

The block also drives a hold/track control for the sampling stage and an output-enable for the data pin. It raises a one-cycle pulse when a frame completes, and a different one when a frame is cut short.

A falling chip select puts the first zero on the pin at once. Each later bit is launched by a falling serial clock edge. The sampler goes back to track on the rising edge that follows the thirteenth falling edge. Raising chip select early ends the frame and releases the pin.

Top module: `serial_sample_engine`

## Requirements
- R1: After chip select falls, the block sets `holdOut` to 1 and `sdoEn` to 1, and `sdo` reads 0 (the first leading zero).
- R2: After k falling serial clock edges (k from 1 to 15), `sdo` equals bit 15−k of the frame word {4'b0000, sample}. Bit 15 is sent first.
- R3: The sample is taken from `sampleIn` at the chip-select fall. Later changes on `sampleIn` during the frame do not alter the bits shifted out.
- R4: `holdOut` stays 1 through the first 13 falling serial clock edges. It drops to 0 on the rising edge that follows the 13th falling edge.
- R5: On the 16th falling edge, `sdoEn` goes to 0 and `frameDone` pulses high for exactly one system clock.
- R6: If chip select rises before the 16th falling edge, `sdoEn` and `holdOut` go to 0 and `frameAbort` pulses for one system clock. `frameDone` does not pulse.
- R7: After the 16th falling edge, further serial clock edges change no output while chip select stays low. The later chip-select rise produces no `frameAbort`.
- R8: While `sdoEn` is 0, `sdo` reads 0. After reset, `sdoEn`, `holdOut`, `frameDone` and `frameAbort` are all 0.
- R9: While chip select is high, serial clock edges leave `sdoEn` and `holdOut` at 0. A new frame starts only on the next chip-select fall.
- R10: Each output responds to a pin edge within three system clocks. The input synchronizers account for two of these clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the host |
| sclkIn | input | 1 | Serial clock from the host |
| sampleIn | input | 12 | Parallel sample word from the conversion stage |
| sdo | output | 1 | Serial data bit; reads 0 when not enabled |
| sdoEn | output | 1 | Output-enable for the three-state data pin |
| holdOut | output | 1 | 1 = hold, 0 = track |
| frameDone | output | 1 | One-cycle pulse on a complete 16-clock frame |
| frameAbort | output | 1 | One-cycle pulse on a frame ended early |

## Verification
The assertions assume three things about the inputs:
- `csN` and `sclkIn` each stay put for more than three system clocks between changes, so no edge is lost in the synchronizers.
- An edge on one pin never lands in the same system clock as an edge on the other.
- `sampleIn` is steady around the chip-select fall.

The stimulus drives every pin change a fixed offset after a clock edge. It picks serial clock half-periods between four and seven system clocks, and it holds `sampleIn` from before chip select falls until after the capture. It alters `sampleIn` only once the word has been latched.

// File: rtl/sse_pkg.sv
package sse_pkg;
  localparam int DataW      = 12;
  localparam int LeadZeros  = 4;
  localparam int FrameLen   = DataW + LeadZeros;
  localparam int ReleaseAt  = 13;
  localparam int CountW     = $clog2(FrameLen + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } sseState_t;

  typedef struct packed {
    logic loadWord;
    logic shiftBit;
  } sseStrobe_t;
endpackage

// File: rtl/sse_edge_sync.sv
module sse_edge_sync #(
  parameter int   Stages = 2,
  parameter logic RstVal = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [Stages:0] syncQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= {(Stages + 1){RstVal}};
    else        syncQ <= {syncQ[Stages-1:0], din};
  end

  assign rise = syncQ[Stages-1] & ~syncQ[Stages];
  assign fall = ~syncQ[Stages-1] & syncQ[Stages];
endmodule

// File: rtl/sse_control.sv
module sse_control
  import sse_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       sclkFall,
  input  logic       sclkRise,
  output sseStrobe_t strobe,
  output logic       driveEn,
  output logic       holdOut,
  output logic       frameDone,
  output logic       frameAbort
);
  sseState_t   state;
  logic [CountW-1:0] fallCnt;
  logic [CountW-1:0] fallNext;

  assign fallNext = fallCnt + CountW'(1);

  always_comb begin
    strobe.loadWord = (state == ST_IDLE) && csFall;
    strobe.shiftBit = (state == ST_SHIFT) && !csRise && sclkFall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fallCnt    <= '0;
      driveEn    <= 1'b0;
      holdOut    <= 1'b0;
      frameDone  <= 1'b0;
      frameAbort <= 1'b0;
    end else begin
      frameDone  <= 1'b0;
      frameAbort <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (csFall) begin
            state   <= ST_SHIFT;
            fallCnt <= '0;
            driveEn <= 1'b1;
            holdOut <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (csRise) begin
            state      <= ST_IDLE;
            driveEn    <= 1'b0;
            holdOut    <= 1'b0;
            frameAbort <= 1'b1;
          end else if (sclkFall) begin
            fallCnt <= fallNext;
            if (fallNext == CountW'(FrameLen)) begin
              state     <= ST_DONE;
              driveEn   <= 1'b0;
              holdOut   <= 1'b0;
              frameDone <= 1'b1;
            end
          end else if (sclkRise && fallCnt >= CountW'(ReleaseAt)) begin
            holdOut <= 1'b0;
          end
        end
        ST_DONE: begin
          if (csRise) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sse_datapath.sv
module sse_datapath
  import sse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sseStrobe_t       strobe,
  input  logic [DataW-1:0] sampleIn,
  output logic             msbBit
);
  logic [FrameLen-1:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               shiftReg <= '0;
    else if (strobe.loadWord) shiftReg <= {{LeadZeros{1'b0}}, sampleIn};
    else if (strobe.shiftBit) shiftReg <= {shiftReg[FrameLen-2:0], 1'b0};
  end

  assign msbBit = shiftReg[FrameLen-1];
endmodule

// File: rtl/serial_sample_engine.sv
module serial_sample_engine
  import sse_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csN,
  input  logic             sclkIn,
  input  logic [DataW-1:0] sampleIn,
  output logic             sdo,
  output logic             sdoEn,
  output logic             holdOut,
  output logic             frameDone,
  output logic             frameAbort
);
  logic csRise, csFall, sclkRise, sclkFall, msbBit;
  sseStrobe_t strobe;

  sse_edge_sync #(.Stages(SyncStages), .RstVal(1'b1)) u_csSync (
    .clk(clk), .rst_n(rst_n), .din(csN), .rise(csRise), .fall(csFall));

  sse_edge_sync #(.Stages(SyncStages), .RstVal(1'b1)) u_sclkSync (
    .clk(clk), .rst_n(rst_n), .din(sclkIn), .rise(sclkRise), .fall(sclkFall));

  sse_control u_ctl (
    .clk(clk), .rst_n(rst_n), .csFall(csFall), .csRise(csRise),
    .sclkFall(sclkFall), .sclkRise(sclkRise), .strobe(strobe),
    .driveEn(sdoEn), .holdOut(holdOut), .frameDone(frameDone),
    .frameAbort(frameAbort));

  sse_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sampleIn(sampleIn),
    .msbBit(msbBit));

  assign sdo = msbBit & sdoEn;
endmodule

// File: rtl/sse_checker.sv
module sse_checker (
  input logic clk,
  input logic rst_n,
  input logic sdo,
  input logic sdoEn,
  input logic holdOut,
  input logic frameDone,
  input logic frameAbort
);
  p_enable_with_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdoEn) |-> holdOut);

  p_hold_rises_with_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdOut) |-> $rose(sdoEn));

  p_done_releases_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> (!sdoEn && $past(sdoEn)));

  p_abort_releases_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frameAbort |-> (!sdoEn && !holdOut && $past(sdoEn)));

  p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frameDone && frameAbort));

  p_pulse_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);

  p_quiet_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sdoEn |-> !sdo);
endmodule

bind serial_sample_engine sse_checker u_sseChk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdoEn(sdoEn), .holdOut(holdOut),
  .frameDone(frameDone), .frameAbort(frameAbort));

// File: tb/serial_sample_engine_tb.sv
module serial_sample_engine_tb;
  localparam int ClkPeriod = 10;
  localparam int Settle    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1;
  logic sclkIn = 1'b1;
  logic [11:0] sampleIn = '0;
  logic sdo, sdoEn, holdOut, frameDone, frameAbort;
  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  int abortCnt = 0;

  always #(ClkPeriod/2) clk = ~clk;

  serial_sample_engine u_dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclkIn(sclkIn), .sampleIn(sampleIn),
    .sdo(sdo), .sdoEn(sdoEn), .holdOut(holdOut), .frameDone(frameDone),
    .frameAbort(frameAbort));

  always @(posedge clk) begin
    if (frameDone)  doneCnt  <= doneCnt + 1;
    if (frameAbort) abortCnt <= abortCnt + 1;
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic frameBit(input logic [11:0] word, input int k);
    logic [15:0] f;
    f = {4'b0000, word};
    return f[15-k];
  endfunction

  task automatic runFrame(input logic [11:0] word, input int falls, input int hp,
                          input bit mutate, input bit extra);
    int d0, a0;
    sampleIn = word;
    waitClk(1);
    csN = 1'b0;
    waitClk(Settle);
    d0 = doneCnt; a0 = abortCnt;
    chk("R1 hold", holdOut, 1);
    chk("R1 enable", sdoEn, 1);
    chk("R1 first zero", sdo, 0);
    if (mutate) sampleIn = ~word;
    for (int k = 1; k <= falls; k++) begin
      sclkIn = 1'b0;
      waitClk(hp);
      if (k < 16) begin
        chk(mutate ? "R3 latched bit" : "R2 bit", sdo, frameBit(word, k));
        chk("R2 enable", sdoEn, 1);
        chk("R4 hold after fall", holdOut, (k <= 13) ? 1 : 0);
      end else begin
        chk("R5 enable off", sdoEn, 0);
        chk("R5 done pulse", doneCnt, d0 + 1);
        chk("R8 quiet pin", sdo, 0);
      end
      sclkIn = 1'b1;
      waitClk(hp);
      if (k < 16) chk("R4 hold after rise", holdOut, (k < 13) ? 1 : 0);
    end
    if (falls == 16 && extra) begin
      for (int j = 0; j < 3; j++) begin
        sclkIn = 1'b0; waitClk(hp);
        sclkIn = 1'b1; waitClk(hp);
      end
      chk("R7 enable stays off", sdoEn, 0);
      chk("R7 hold stays off", holdOut, 0);
      chk("R7 sdo stays low", sdo, 0);
      chk("R7 no extra done", doneCnt, d0 + 1);
    end
    csN = 1'b1;
    waitClk(Settle);
    if (falls < 16) begin
      chk("R6 abort pulse", abortCnt, a0 + 1);
      chk("R6 enable off", sdoEn, 0);
      chk("R6 hold off", holdOut, 0);
      chk("R6 no done", doneCnt, d0);
    end else begin
      chk("R7 no abort", abortCnt, a0);
    end
    sclkIn = 1'b0; waitClk(Settle);
    sclkIn = 1'b1; waitClk(Settle);
    chk("R9 idle enable", sdoEn, 0);
    chk("R9 idle hold", holdOut, 0);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5150);
    waitClk(3);
    chk("R8 reset enable", sdoEn, 0);
    chk("R8 reset hold", holdOut, 0);
    chk("R8 reset done", frameDone, 0);
    chk("R8 reset abort", frameAbort, 0);
    rst_n = 1'b1;
    waitClk(Settle);
    // R10: the fixed Settle of 4 clocks covers the three-clock response
    runFrame(12'hFFF, 16, 4, 1'b0, 1'b1);
    runFrame(12'hA5C, 16, 5, 1'b1, 1'b0);
    runFrame(12'h800, 13, 4, 1'b0, 1'b0);
    runFrame(12'h001, 0, 4, 1'b0, 1'b0);
    runFrame(12'h7FF, 15, 6, 1'b0, 1'b0);
    for (int n = 0; n < 40; n++) begin
      int falls;
      falls = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 16;
      runFrame(12'($urandom), falls, $urandom_range(4, 7),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule